// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 / Clause 45)

This block is a bus master for the two-wire Ethernet PHY management interface. It generates the management clock (MDC) from the system clock and shifts management frames out on the data line (MDIO). It also samples the PHY's reply during read frames. A single configuration bit selects Clause 22 or Clause 45 framing, so the same register set serves both formats.

Software controls the block through four 32-bit word registers on a simple write-strobe bus. Each frame is started by a write to one particular register:
- A write to the address register sends a Clause 45 address frame.
- A write to the data register sends a write frame.
- A write to the control register with its read bit set sends a read frame.

A busy flag covers the whole frame. Read data stays in the data register until the next read starts. A read-error flag records a PHY that did not pull the line low during the read turnaround.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the status word reads 0x0000_0280 (divider 5, all other fields 0). MDC is low, the MDIO output enable is low, and the data, control and address registers read 0.
- R2: Word registers sit at byte offsets 0x30 (status/config), 0x34 (control), 0x38 (data) and 0x3C (address). Read data appears on bus_rdata one clock after bus_addr is presented.
  - Status fields: busy bit 0, read error bit 1, preamble-off bit 5, Clause 45 select bit 6, divider bits 15:7.
  - Control fields: device/register number bits 4:0, PHY address bits 9:5, read command bit 15 (the read command bit is not stored).
  - Data and address registers hold bits 15:0.
- R3: While a frame runs, MDC has a period of 2·d+1 clocks: low for d+1 clocks, then high for d clocks. Here d is the programmed divider, or 5 when the programmed value is below 5. The status register reads back the value as written.
- R4: A data-register write in Clause 22 mode sends the 32-bit frame {01, 01, phy[4:0], reg[4:0], 10, data[15:0]}, most significant bit first.
- R5: In Clause 45 mode, a data-register write sends {00, 01, phy, dev, 10, data}. An address-register write sends {00, 00, phy, dev, 10, addr}. In Clause 22 mode, an address-register write only stores the value and sends nothing.
- R6: A control write with bit 15 set sends {start, op, phy, dev} followed by the turnaround and 16 data bits, with op 10 in Clause 22 or 11 in Clause 45. The output enable is released from the first turnaround bit to the end of the frame. The 16 sampled bits are loaded into the data register when the frame ends.
- R7: If the line is high at the second turnaround bit of a read, the read-error bit is set and stays set. It is cleared when the next read starts. With no PHY answering, the pulled-up line yields data 0xFFFF.
- R8: Unless preamble-off is set, each frame is preceded by 32 one bits, giving 64 MDC periods. With preamble-off set, the frame is 32 periods long.
- R9: Busy is set on the clock after a frame-starting write and clears after the last bit period. While busy is clear, MDC is low and the output enable is low.
- R10: Register writes made while busy is set have no effect: no frame starts, and the configuration, control and data contents are unchanged.
- R11: The master changes MDIO only when MDC falls (or at frame start/end with MDC low), and samples read data at the MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Value driven on the MDIO line |
| mdio_oe | output | 1 | Drive enable for the MDIO line |
| mdio_i | input | 1 | Sampled MDIO line value |

## Verification
The two functions that can fall in the same cycle are a running frame and a new register write: software may write the data, control or status register while busy is still set. The bench provokes this by writing another data value, a read command and a new divider part-way through a write frame. It then judges the outcome at the ports: exactly one 32-bit frame must appear on the line, carrying the first value, and the data, control and divider readbacks must still hold their pre-frame contents.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_CTL  = 8'h34;
  localparam logic [7:0] OFS_DATA = 8'h38;
  localparam logic [7:0] OFS_ADDR = 8'h3C;

  typedef enum logic [1:0] {
    FR_ADDR  = 2'd0,
    FR_WRITE = 2'd1,
    FR_READ  = 2'd2
  } frame_kind_e;

  // Assembles the 32-bit management frame, MSB sent first.
  function automatic logic [31:0] build_frame(
    input logic        c45,
    input frame_kind_e kind,
    input logic [4:0]  phy,
    input logic [4:0]  dev,
    input logic [15:0] payload
  );
    logic [1:0] st;
    logic [1:0] op;
    logic [1:0] ta;
    st = c45 ? 2'b00 : 2'b01;
    case (kind)
      FR_ADDR:  op = 2'b00;
      FR_WRITE: op = 2'b01;
      default:  op = c45 ? 2'b11 : 2'b10;
    endcase
    ta = (kind == FR_READ) ? 2'b11 : 2'b10;
    return {st, op, phy, dev, ta, payload};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             end_stb
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] last;
  logic [CW-1:0] half;

  always_comb begin
    last     = {div, 1'b0};
    half     = {1'b0, div};
    rise_stb = run && (cnt == half);
    end_stb  = run && (cnt == last);
    cnt_nx   = end_stb ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      mdc <= (cnt_nx > half);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int FRAME_W = 32,
  parameter int PRE_W   = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               is_read,
  input  logic               pre_dis,
  input  logic               rise_stb,
  input  logic               end_stb,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdo,
  output logic               oe,
  output logic [DATA_W-1:0]  rx_data,
  output logic               rx_err,
  output logic               rd_done
);
  localparam int TOT_W  = FRAME_W + PRE_W;
  localparam int CNT_W  = $clog2(TOT_W);
  localparam int FIDX_W = $clog2(FRAME_W);
  localparam int TA_HI  = DATA_W + 1;

  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   bcnt;
  logic [CNT_W-1:0]   nxt;
  logic               rd_q;
  logic               bit_nx;

  always_comb begin
    nxt    = bcnt - 1'b1;
    bit_nx = (nxt >= CNT_W'(FRAME_W)) ? 1'b1 : frame_q[nxt[FIDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      frame_q <= '0;
      bcnt    <= '0;
      rd_q    <= 1'b0;
      mdo     <= 1'b1;
      oe      <= 1'b0;
      rx_data <= '0;
      rx_err  <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          frame_q <= frame;
          rd_q    <= is_read;
          bcnt    <= pre_dis ? CNT_W'(FRAME_W - 1) : CNT_W'(TOT_W - 1);
          mdo     <= pre_dis ? frame[FRAME_W-1] : 1'b1;
          oe      <= 1'b1;
          if (is_read) rx_err <= 1'b0;
        end
      end else begin
        if (rise_stb && rd_q) begin
          if (bcnt == CNT_W'(DATA_W)) rx_err <= mdio_i;
          if (bcnt < CNT_W'(DATA_W)) rx_data <= {rx_data[DATA_W-2:0], mdio_i};
        end
        if (end_stb) begin
          if (bcnt == '0) begin
            busy    <= 1'b0;
            oe      <= 1'b0;
            mdo     <= 1'b1;
            rd_done <= rd_q;
          end else begin
            bcnt <= nxt;
            mdo  <= bit_nx;
            oe   <= !(rd_q && (nxt <= CNT_W'(TA_HI)));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DIV_W   = 9,
  parameter int DIV_RST = 5,
  parameter int DIV_MIN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 32;
  localparam int DIV_LSB = 7;

  logic [DIV_W-1:0]  cfg_div;
  logic              cfg_c45;
  logic              cfg_pre;
  logic [4:0]        ctl_phy;
  logic [4:0]        ctl_dev;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] addr_q;
  logic [DIV_W-1:0]  div_eff;

  logic busy, rise_stb, end_stb, rd_done, rx_err;
  logic [DATA_W-1:0] rx_data;

  logic wr_stat, wr_ctl, wr_data, wr_addr;
  logic go, go_read;
  frame_kind_e kind;
  logic [4:0] sel_phy, sel_dev;
  logic [DATA_W-1:0] payload;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    wr_stat = bus_wen && !busy && (bus_addr == ADDR_W'(OFS_STAT));
    wr_ctl  = bus_wen && !busy && (bus_addr == ADDR_W'(OFS_CTL));
    wr_data = bus_wen && !busy && (bus_addr == ADDR_W'(OFS_DATA));
    wr_addr = bus_wen && !busy && (bus_addr == ADDR_W'(OFS_ADDR));
    div_eff = (cfg_div < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : cfg_div;

    go_read = wr_ctl && bus_wdata[15];
    go      = go_read || wr_data || (wr_addr && cfg_c45);
    sel_phy = wr_ctl ? bus_wdata[9:5] : ctl_phy;
    sel_dev = wr_ctl ? bus_wdata[4:0] : ctl_dev;
    if (go_read) begin
      kind    = FR_READ;
      payload = '1;
    end else if (wr_data) begin
      kind    = FR_WRITE;
      payload = bus_wdata[DATA_W-1:0];
    end else begin
      kind    = FR_ADDR;
      payload = bus_wdata[DATA_W-1:0];
    end
    frame = build_frame(cfg_c45, kind, sel_phy, sel_dev, payload);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div <= DIV_W'(DIV_RST);
      cfg_c45 <= 1'b0;
      cfg_pre <= 1'b0;
      ctl_phy <= '0;
      ctl_dev <= '0;
      data_q  <= '0;
      addr_q  <= '0;
    end else begin
      if (wr_stat) begin
        cfg_div <= bus_wdata[DIV_LSB +: DIV_W];
        cfg_c45 <= bus_wdata[6];
        cfg_pre <= bus_wdata[5];
      end
      if (wr_ctl) begin
        ctl_phy <= bus_wdata[9:5];
        ctl_dev <= bus_wdata[4:0];
      end
      if (wr_data) data_q <= bus_wdata[DATA_W-1:0];
      else if (rd_done) data_q <= rx_data;
      if (wr_addr) addr_q <= bus_wdata[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_addr == ADDR_W'(OFS_STAT)) begin
        bus_rdata[DIV_LSB +: DIV_W] <= cfg_div;
        bus_rdata[6] <= cfg_c45;
        bus_rdata[5] <= cfg_pre;
        bus_rdata[1] <= rx_err;
        bus_rdata[0] <= busy;
      end else if (bus_addr == ADDR_W'(OFS_CTL)) begin
        bus_rdata[9:0] <= {ctl_phy, ctl_dev};
      end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
        bus_rdata[DATA_W-1:0] <= data_q;
      end else if (bus_addr == ADDR_W'(OFS_ADDR)) begin
        bus_rdata[DATA_W-1:0] <= addr_q;
      end
    end
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .div(div_eff),
    .mdc(mdc), .rise_stb(rise_stb), .end_stb(end_stb)
  );

  mdio_frame_engine #(.FRAME_W(FRAME_W), .PRE_W(32), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .start(go), .frame(frame), .is_read(go_read),
    .pre_dis(cfg_pre), .rise_stb(rise_stb), .end_stb(end_stb), .mdio_i(mdio_i),
    .busy(busy), .mdo(mdio_o), .oe(mdio_oe), .rx_data(rx_data),
    .rx_err(rx_err), .rd_done(rd_done)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int DIV_W  = 9,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              bus_wen,
  input logic [DIV_W-1:0]  cfg_div,
  input logic [DIV_W-1:0]  div_eff,
  input logic [DATA_W-1:0] data_q
);
  localparam int CYC_W = DIV_W + 2;

  logic [CYC_W-1:0] cyc;
  logic             seen;
  logic             mdc_d;

  a_r9_mdc_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  a_r9_oe_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  a_r11_drive_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);

  a_r10_busy_write_cfg: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wen) |=> $stable(cfg_div));

  a_r10_busy_write_data: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wen) |=> $stable(data_q));

  // R3: spacing of MDC rising edges inside one frame
  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      cyc   <= '0;
      seen  <= 1'b0;
      mdc_d <= 1'b0;
    end else begin
      mdc_d <= mdc;
      if (mdc && !mdc_d) begin
        if (seen) begin
          a_r3_mdc_period: assert (cyc == ({1'b0, div_eff, 1'b0} + 1'b1));
        end
        cyc  <= CYC_W'(1);
        seen <= 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .bus_wen(bus_wen), .cfg_div(cfg_div),
  .div_eff(div_eff), .data_q(data_q)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam logic [7:0] A_STAT = 8'h30;
  localparam logic [7:0] A_CTL  = 8'h34;
  localparam logic [7:0] A_DATA = 8'h38;
  localparam logic [7:0] A_ADDR = 8'h3C;

  // {c45, pre_off, phy[4:0], reg/dev[4:0], data[15:0]}
  localparam logic [27:0] VEC [4] = '{
    {1'b0, 1'b0, 5'h01, 5'h02, 16'hA5C3},
    {1'b0, 1'b1, 5'h1F, 5'h00, 16'h0001},
    {1'b1, 1'b0, 5'h03, 5'h1E, 16'hFFFF},
    {1'b1, 1'b1, 5'h10, 5'h05, 16'h8000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_drv = 1'b0;
  logic phy_val = 1'b1;

  always #10 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_mgmt_master uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  int ncap = 0;
  logic cap_on = 1'b0;
  logic phy_present = 1'b0;
  logic rd_active = 1'b0;
  logic [15:0] phy_data = '0;
  int phy_base = 0;

  always @(posedge mdc) begin
    if (cap_on) begin
      cap   = {cap[62:0], mdio_i};
      oecap = {oecap[62:0], mdio_oe};
      ncap  = ncap + 1;
    end
  end

  // Responding PHY: drives the second turnaround bit and 16 data bits
  always @(negedge mdc) begin
    int k;
    k = ncap - phy_base - 15;
    if (rd_active && phy_present && k >= 0 && k <= 16) begin
      phy_drv = 1'b1;
      phy_val = (k == 0) ? 1'b0 : phy_data[16-k];
    end else begin
      phy_drv = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic arm(input logic pre_off);
    cap = '0; oecap = '0; ncap = 0; cap_on = 1'b1;
    phy_base = pre_off ? 0 : 32;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(A_STAT, v);
      if (!v[0]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] stat_word(input int div, input logic c45, input logic pre);
    return (32'(div) << 7) | (32'(c45) << 6) | (32'(pre) << 5);
  endfunction

  // Line image of a frame as the requirements define it
  function automatic logic [31:0] exp_wr(input logic c45, input logic is_addr,
      input logic [4:0] phy, input logic [4:0] dev, input logic [15:0] d);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    op = is_addr ? 2'b00 : 2'b01;
    return {st, op, phy, dev, 2'b10, d};
  endfunction

  function automatic logic [31:0] exp_rd(input logic c45, input logic [4:0] phy,
      input logic [4:0] dev, input logic present, input logic [15:0] d);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    op = c45 ? 2'b11 : 2'b10;
    return {st, op, phy, dev, 1'b1, !present, present ? d : 16'hFFFF};
  endfunction

  task automatic do_read(input logic c45, input logic pre, input logic [4:0] phy,
      input logic [4:0] dev, input logic present, input logic [15:0] d, input string tag);
    logic [31:0] v;
    wr(A_STAT, stat_word(5, c45, pre));
    phy_present = present; phy_data = d; rd_active = 1'b1;
    arm(pre);
    wr(A_CTL, 32'h8000 | {22'd0, phy, dev});
    wait_idle();
    rd_active = 1'b0;
    chk({tag, " R6 read frame on line"}, {32'd0, cap[31:0]}, {32'd0, exp_rd(c45, phy, dev, present, d)});
    chk({tag, " R6 oe released from turnaround"}, {46'd0, oecap[17:0]}, {46'd0, 18'd0});
    chk({tag, " R6 oe driven before turnaround"}, {63'd0, oecap[18]}, 64'd1);
    rd(A_DATA, v);
    chk({tag, " R6 R7 data register"}, {32'd0, v}, {48'd0, present ? d : 16'hFFFF});
    rd(A_STAT, v);
    chk({tag, " R7 read error bit"}, {63'd0, v[1]}, {63'd0, !present});
  endtask

  task automatic measure(input int div, input string tag);
    realtime t1, t2, t3;
    wr(A_STAT, stat_word(div, 1'b0, 1'b0));
    arm(1'b0);
    wr(A_DATA, 32'h0000_5A5A);
    @(posedge mdc); t1 = $realtime;
    @(negedge mdc); t2 = $realtime;
    @(posedge mdc); t3 = $realtime;
    wait_idle();
    chk({tag, " R3 mdc period"}, 64'($rtoi((t3 - t1) / 20.0)), 64'(2 * ((div < 5) ? 5 : div) + 1));
    chk({tag, " R3 mdc high time"}, 64'($rtoi((t2 - t1) / 20.0)), 64'((div < 5) ? 5 : div));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, v);
    chk("R1 status after reset", {32'd0, v}, 64'h280);
    chk("R1 mdc and oe after reset", {62'd0, mdc, mdio_oe}, 64'd0);
    rd(A_DATA, v);
    chk("R1 data after reset", {32'd0, v}, 64'd0);

    // R2 readback, R5 address write in Clause 22 sends nothing
    wr(A_CTL, 32'h0000_02A3);
    rd(A_CTL, v);
    chk("R2 control readback", {32'd0, v}, 64'h2A3);
    arm(1'b0);
    wr(A_ADDR, 32'h0000_BEAD);
    repeat (60) @(negedge clk);
    chk("R5 no frame for clause 22 address write", 64'(ncap), 64'd0);
    rd(A_ADDR, v);
    chk("R2 address readback", {32'd0, v}, 64'hBEAD);

    // R4 R5 R8 write frames from the vector table
    foreach (VEC[i]) begin
      logic c45, pre;
      c45 = VEC[i][27]; pre = VEC[i][26];
      wr(A_STAT, stat_word(5, c45, pre));
      wr(A_CTL, {22'd0, VEC[i][25:21], VEC[i][20:16]});
      arm(pre);
      wr(A_DATA, {16'd0, VEC[i][15:0]});
      if (i == 0) begin
        rd(A_STAT, v);
        chk("R9 busy set after command", {63'd0, v[0]}, 64'd1);
      end
      wait_idle();
      chk($sformatf("R8 bit count vec%0d", i), 64'(ncap), pre ? 64'd32 : 64'd64);
      chk($sformatf("R4 R5 frame vec%0d", i), {32'd0, cap[31:0]},
          {32'd0, exp_wr(c45, 1'b0, VEC[i][25:21], VEC[i][20:16], VEC[i][15:0])});
      if (!pre) chk($sformatf("R8 preamble ones vec%0d", i), {32'd0, cap[63:32]}, 64'hFFFF_FFFF);
      chk($sformatf("R9 idle lines vec%0d", i), {62'd0, mdc, mdio_oe}, 64'd0);
    end

    // R5 Clause 45 address frame
    wr(A_STAT, stat_word(5, 1'b1, 1'b1));
    wr(A_CTL, {22'd0, 5'h07, 5'h01});
    arm(1'b1);
    wr(A_ADDR, 32'h0000_1234);
    wait_idle();
    chk("R5 address frame", {32'd0, cap[31:0]}, {32'd0, exp_wr(1'b1, 1'b1, 5'h07, 5'h01, 16'h1234)});

    // R6 R7 reads
    do_read(1'b0, 1'b0, 5'h04, 5'h11, 1'b1, 16'hBEEF, "c22 present");
    do_read(1'b1, 1'b1, 5'h09, 5'h03, 1'b0, 16'h0000, "c45 absent");
    do_read(1'b1, 1'b1, 5'h09, 5'h03, 1'b1, 16'h1C3E, "c45 present clears error");

    // R10 writes while busy are ignored
    wr(A_STAT, stat_word(5, 1'b0, 1'b1));
    wr(A_CTL, {22'd0, 5'h02, 5'h03});
    arm(1'b1);
    wr(A_DATA, 32'h0000_1111);
    repeat (50) @(negedge clk);
    wr(A_DATA, 32'h0000_2222);
    wr(A_CTL, 32'h0000_8000 | {22'd0, 5'h1B, 5'h1C});
    wr(A_STAT, stat_word(9, 1'b1, 1'b0));
    wait_idle();
    repeat (200) @(negedge clk);
    chk("R10 single frame only", 64'(ncap), 64'd32);
    chk("R10 frame carries first value", {48'd0, cap[15:0]}, 64'h1111);
    rd(A_DATA, v);
    chk("R10 data unchanged", {32'd0, v}, 64'h1111);
    rd(A_STAT, v);
    chk("R10 config unchanged", {32'd0, v}, {32'd0, stat_word(5, 1'b0, 1'b1)});
    rd(A_CTL, v);
    chk("R10 control unchanged", {32'd0, v}, {54'd0, 5'h02, 5'h03});

    // R3 divider, including clamping below 5
    measure(7, "div7");
    measure(2, "div2");
    rd(A_STAT, v);
    chk("R3 divider reads as written", {55'd0, v[15:7]}, 64'd2);

    summary();
  end
endmodule